// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and the calendar in seven BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. An external prescaler supplies a one-cycle pulse once per second. On each accepted pulse the seconds advance, and any carry ripples through to the higher fields in the same clock cycle. Month lengths and the leap-year February are worked out from the stored month and year, so no software correction is needed.

The hours register also holds the format. Bit 7 of the hours register selects 12-hour mode. In that mode bit 5 is the PM flag and bits 4:0 hold the hour 01 to 12. In 24-hour mode bits 5:0 hold the hour 00 to 23. A host loads any field through a one-cycle write port and can read any field back at any time through a combinational read port. Field index 0 is seconds, 1 is minutes and 2 is hours. Indices 3 to 6 are day of week, date, month and year.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour mode), day of week 1, date 01, month 01 and year 00.
- R2: A write with `wr_en_i` high stores `wr_data_i` into the field at `wr_addr_i` (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year). Bits outside a field read as zero: bit 7 of seconds and minutes, bit 6 of hours, bits 7:3 of day of week, bits 7:6 of date and bits 7:5 of month. Read index 7 returns 00.
- R3: Each accepted tick advances seconds by one in BCD. Seconds 59 wraps to 00 and advances minutes. Minutes 59 wraps to 00 and advances hours.
- R4: In 24-hour mode (hours bit 7 = 0) the hour counts 00 to 23. Hour 23 wraps to 00 and starts a new day.
- R5: In 12-hour mode (hours bit 7 = 1, bit 5 = PM) the hour runs 12, 01, …, 11. The step from 11 to 12 toggles PM. The step from 11 PM to 12 AM starts a new day. The step from 12 to 01 keeps the PM flag.
- R6: Each new day advances the day of week from 1 to 7, and 7 wraps to 1.
- R7: Date wraps to 01 and month advances after day 30 of April, June, September and November, and after day 31 of every other month except February.
- R8: February ends after day 29 when the BCD year is divisible by 4 (00 included) and after day 28 otherwise.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R10: A tick arriving in the same cycle as a write is discarded. Only the written field changes in that cycle.
- R11: With neither tick nor write, no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle one-second pulse |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 3 | Field index for write |
| wr_data_i | input | 8 | BCD value to write |
| rd_addr_i | input | 3 | Field index for read |
| rd_data_o | output | 8 | Selected field, combinational |

## Verification
The bench presets the full register set and applies a single tick at each rollover boundary. These boundaries are 23:59:59 on the last day of 30- and 31-day months, February in leap years (including year 00) and in common years, New Year's Eve with year 99, and the 12-hour steps 11 AM, 11 PM and 12 AM. The faults it targets are:
- a wrong month-length table, which ends a month a day early or late;
- a leap test that misses year 00 or a tens-digit case, which ends February on the wrong day;
- a PM toggle on the wrong step, which flips AM/PM at 12→01 or starts a new day at 11 AM.

It also checks masking of unused bits on write. It holds the tick high together with a write to show that the write wins and the tick is lost, where a faulty design would advance seconds. Sixty consecutive ticks show that the carry is produced exactly once per minute.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W    = 8;
  localparam int ADDR_W     = 3;
  localparam int NUM_FIELDS = 7;

  typedef enum logic [ADDR_W-1:0] {
    F_SEC   = 3'd0,
    F_MIN   = 3'd1,
    F_HOUR  = 3'd2,
    F_DOW   = 3'd3,
    F_DATE  = 3'd4,
    F_MONTH = 3'd5,
    F_YEAR  = 3'd6
  } field_e;

  // Add one to a two-digit BCD value; a units digit of 9 or more carries.
  function automatic logic [FIELD_W-1:0] bcd_step(input logic [FIELD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (10*t + u) mod 4 equals (2*t + u) mod 4, so only t[0] and u[1:0] matter.
  function automatic logic leap_year(input logic [FIELD_W-1:0] y);
    logic [1:0] s;
    s = {y[4], 1'b0} + y[1:0];
    return (s == 2'b00);
  endfunction

  // Last date of a month, in BCD.
  function automatic logic [FIELD_W-1:0] month_last(input logic [FIELD_W-1:0] m,
                                                    input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [FIELD_W-1:0] MASK    = 8'hFF,
  parameter logic [FIELD_W-1:0] LO      = 8'h00,
  parameter logic [FIELD_W-1:0] RST_VAL = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_i,
  input  logic [FIELD_W-1:0] ld_val_i,
  input  logic               inc_i,
  input  logic [FIELD_W-1:0] limit_i,
  output logic [FIELD_W-1:0] q_o,
  output logic               wrap_o
);
  logic [FIELD_W-1:0] nxt;

  assign wrap_o = inc_i && (q_o >= limit_i);

  always_comb begin
    nxt = q_o;
    if (ld_i)       nxt = ld_val_i & MASK;
    else if (inc_i) nxt = wrap_o ? LO : (bcd_step(q_o) & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST_VAL;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_i,
  input  logic [FIELD_W-1:0] ld_val_i,
  input  logic               inc_i,
  output logic [FIELD_W-1:0] q_o,
  output logic               day_o
);
  localparam logic [FIELD_W-1:0] HOUR_MASK = 8'hBF;

  logic               mode12;
  logic               pm;
  logic [FIELD_W-1:0] hv;
  logic [FIELD_W-1:0] stepped;
  logic [FIELD_W-1:0] nxt;

  assign mode12 = q_o[7];
  assign pm     = q_o[5];

  always_comb begin
    nxt     = q_o;
    day_o   = 1'b0;
    hv      = mode12 ? {3'b000, q_o[4:0]} : {2'b00, q_o[5:0]};
    stepped = bcd_step(hv);
    if (ld_i) begin
      nxt = ld_val_i & HOUR_MASK;
    end else if (inc_i) begin
      if (mode12) begin
        if (hv >= 8'h12) begin
          nxt = {q_o[7], 1'b0, pm, 5'h01};
        end else if (hv == 8'h11) begin
          nxt   = {q_o[7], 1'b0, ~pm, 5'h12};
          day_o = pm;
        end else begin
          nxt = {q_o[7], 1'b0, pm, stepped[4:0]};
        end
      end else begin
        if (hv >= 8'h23) begin
          nxt   = {q_o[7], 7'h00};
          day_o = 1'b1;
        end else begin
          nxt = {q_o[7], 1'b0, stepped[5:0]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 8'h00;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [FIELD_W-1:0] rd_data_o
);
  localparam int MS_FIELDS = 2;

  logic [NUM_FIELDS-1:0] ld;
  logic                  tick_ok;
  logic [FIELD_W-1:0]    ms_q    [MS_FIELDS];
  logic [MS_FIELDS:0]    ms_carry;
  logic [FIELD_W-1:0]    sec_q, min_q, hour_q, dow_q, date_q, month_q, year_q;
  logic                  day_roll, dow_wrap, date_wrap, month_wrap, year_wrap;
  logic [FIELD_W-1:0]    date_limit;

  // R10: a write cycle swallows the tick
  assign tick_ok = tick_i & ~wr_en_i;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_ld
    assign ld[f] = wr_en_i && (wr_addr_i == ADDR_W'(f));
  end

  // Seconds and minutes share one shape: 00..59 with carry out
  assign ms_carry[0] = tick_ok;
  for (genvar i = 0; i < MS_FIELDS; i++) begin : g_ms
    rtc_bcd_field #(.MASK(8'h7F), .LO(8'h00), .RST_VAL(8'h00)) u_ms (
      .clk(clk), .rst_n(rst_n),
      .ld_i(ld[i]), .ld_val_i(wr_data_i),
      .inc_i(ms_carry[i]), .limit_i(8'h59),
      .q_o(ms_q[i]), .wrap_o(ms_carry[i+1])
    );
  end
  assign sec_q = ms_q[0];
  assign min_q = ms_q[1];

  rtc_hour_field u_hour (
    .clk(clk), .rst_n(rst_n),
    .ld_i(ld[F_HOUR]), .ld_val_i(wr_data_i),
    .inc_i(ms_carry[MS_FIELDS]),
    .q_o(hour_q), .day_o(day_roll)
  );

  rtc_bcd_field #(.MASK(8'h07), .LO(8'h01), .RST_VAL(8'h01)) u_dow (
    .clk(clk), .rst_n(rst_n),
    .ld_i(ld[F_DOW]), .ld_val_i(wr_data_i),
    .inc_i(day_roll), .limit_i(8'h07),
    .q_o(dow_q), .wrap_o(dow_wrap)
  );

  assign date_limit = month_last(month_q, leap_year(year_q));

  rtc_bcd_field #(.MASK(8'h3F), .LO(8'h01), .RST_VAL(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n),
    .ld_i(ld[F_DATE]), .ld_val_i(wr_data_i),
    .inc_i(day_roll), .limit_i(date_limit),
    .q_o(date_q), .wrap_o(date_wrap)
  );

  rtc_bcd_field #(.MASK(8'h1F), .LO(8'h01), .RST_VAL(8'h01)) u_month (
    .clk(clk), .rst_n(rst_n),
    .ld_i(ld[F_MONTH]), .ld_val_i(wr_data_i),
    .inc_i(date_wrap), .limit_i(8'h12),
    .q_o(month_q), .wrap_o(month_wrap)
  );

  rtc_bcd_field #(.MASK(8'hFF), .LO(8'h00), .RST_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n),
    .ld_i(ld[F_YEAR]), .ld_val_i(wr_data_i),
    .inc_i(month_wrap), .limit_i(8'h99),
    .q_o(year_q), .wrap_o(year_wrap)
  );

  always_comb begin
    case (rd_addr_i)
      F_SEC:   rd_data_o = sec_q;
      F_MIN:   rd_data_o = min_q;
      F_HOUR:  rd_data_o = hour_q;
      F_DOW:   rd_data_o = dow_q;
      F_DATE:  rd_data_o = date_q;
      F_MONTH: rd_data_o = month_q;
      F_YEAR:  rd_data_o = year_q;
      default: rd_data_o = '0;
    endcase
  end

  logic unused_wraps;
  assign unused_wraps = dow_wrap ^ year_wrap;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] dow_q,
  input logic       day_roll
);
  // R2
  sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_addr_i == 3'd0 |=> sec_q == ($past(wr_data_i) & 8'h7F));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_en_i && sec_q == 8'h59 |=> sec_q == 8'h00);

  // R4
  hour24_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_en_i && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23
    |=> hour_q == 8'h00);

  // R6
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll && dow_q == 8'h07 |=> dow_q == 8'h01);

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_addr_i != 3'd0 |=> $stable(sec_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !wr_en_i |=> $stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(dow_q));
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .dow_q(dow_q),
  .day_roll(day_roll)
);

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;

  // {preset sec,min,hour,dow,date,month,year, expected after one tick in the same order}
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00}, // R3
    {56'h59_00_05_02_10_03_20, 56'h00_01_05_02_10_03_20}, // R3
    {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R9 R6
    {56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23}, // R8 common year
    {56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24}, // R8 leap year
    {56'h59_59_23_05_29_02_00, 56'h00_00_00_06_01_03_00}, // R8 year 00
    {56'h59_59_23_02_30_04_05, 56'h00_00_00_03_01_05_05}, // R7 30-day month
    {56'h59_59_23_07_31_01_05, 56'h00_00_00_01_01_02_05}, // R7 R6
    {56'h59_59_91_02_15_06_10, 56'h00_00_B2_02_15_06_10}, // R5 11 AM -> 12 PM
    {56'h59_59_B1_02_15_06_10, 56'h00_00_92_03_16_06_10}, // R5 11 PM -> 12 AM
    {56'h59_59_92_02_15_06_10, 56'h00_00_81_02_15_06_10}, // R5 12 AM -> 1 AM
    {56'h59_59_09_02_15_06_10, 56'h00_00_10_02_15_06_10}, // R4 BCD carry
    {56'h59_59_23_04_31_12_09, 56'h00_00_00_05_01_01_10}  // R9 year tens carry
  };

  bcd_rtc_core uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic with_tick);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    for (int k = 0; k < n; k++) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [55:0] exp_reset;
    exp_reset = 56'h00_00_00_01_01_01_00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int f = 0; f < 7; f++) begin
      rd(3'(f), d);
      check($sformatf("R1 field %0d", f), d, exp_reset[55-8*f -: 8]);
    end
    rd(3'd7, d);
    check("R2 index 7", d, 8'h00);

    // R2 masking of unused bits
    begin
      logic [7:0] mask [7];
      mask = '{8'h7F, 8'h7F, 8'hBF, 8'h07, 8'h3F, 8'h1F, 8'hFF};
      for (int f = 0; f < 7; f++) begin
        wr(3'(f), 8'hFF, 1'b0);
        rd(3'(f), d);
        check($sformatf("R2 mask field %0d", f), d, mask[f]);
      end
    end

    // Table walk: preset, one tick, compare all fields
    for (int v = 0; v < NVEC; v++) begin
      for (int f = 0; f < 7; f++) wr(3'(f), VEC[v][111-8*f -: 8], 1'b0);
      ticks(1);
      for (int f = 0; f < 7; f++) begin
        rd(3'(f), d);
        check($sformatf("vector %0d field %0d (R3 R4 R5 R6 R7 R8 R9)", v, f), d, VEC[v][55-8*f -: 8]);
      end
    end

    // R3 sixty consecutive ticks give exactly one minute
    wr(3'd0, 8'h00, 1'b0);
    wr(3'd1, 8'h00, 1'b0);
    wr(3'd2, 8'h05, 1'b0);
    ticks(60);
    rd(3'd0, d); check("R3 sixty ticks seconds", d, 8'h00);
    rd(3'd1, d); check("R3 sixty ticks minutes", d, 8'h01);
    ticks(3);
    rd(3'd0, d); check("R3 three more ticks", d, 8'h03);

    // R10 tick during a write is lost
    wr(3'd1, 8'h42, 1'b1);
    rd(3'd0, d); check("R10 seconds unchanged", d, 8'h03);
    rd(3'd1, d); check("R10 minutes written", d, 8'h42);
    wr(3'd0, 8'h10, 1'b1);
    rd(3'd0, d); check("R10 write beats tick same field", d, 8'h10);

    // R11 idle cycles hold everything
    repeat (5) @(negedge clk);
    rd(3'd0, d); check("R11 seconds held", d, 8'h10);
    rd(3'd1, d); check("R11 minutes held", d, 8'h42);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule